// File: doc/BRIEF.md
# Byte Instruction Prefetch Queue with Opcode Loader

This block sits between an 8-bit memory port and an instruction decoder. It fetches instruction bytes ahead of need, one byte per memory transaction, into a four-entry byte queue. It keeps a fetch address that always names the next byte to be requested, not the instruction now executing. Memory is a simple byte source. A request is accepted by a grant, and the byte comes back later with a data-valid strobe. At most one request is outstanding at a time.

On the decode side, a small loader state machine takes the opcode byte out of the queue into a holding register before the decoder asks for it. It presents that byte until the decoder accepts it. If the decoder then asks for an addressing-mode byte, the loader hands over the next queue byte with a one-cycle strobe. The loader then stays out of the way while later logic pulls any further instruction bytes through a separate request port. When the decoder signals that the current instruction is nearly done, the loader fetches the next opcode ahead.

A control-transfer request clears the queue and the held opcode at once. On the same edge it loads the fetch address with the new target. It also drops any byte still in flight from the old stream.

Top module: `pfq_loader`

## Requirements
- R1: After reset the fetch address equals the `RESET_ADDR` parameter, the queue is empty, `mem_req` is high, and `dec_op_vld`, `dec_mode_vld` and `xb_vld` are low.
- R2: Each grant (`mem_req` and `mem_gnt` in the same cycle) advances `mem_addr` by one, modulo 2^ADDR_W. `mem_req` is never high while a granted byte has not yet returned.
- R3: The queue holds at most four bytes. With no consumer activity, exactly five grants occur: four queued bytes plus one held opcode. `mem_req` then stays low.
- R4: Bytes leave through the opcode, mode and extra-byte outputs in the order their addresses were fetched, with no loss or duplication.
- R5: An empty queue stalls every consumer. No opcode is loaded, `dec_mode_vld` and `xb_vld` stay low, and they wait until a byte arrives.
- R6: `dec_op_vld` stays high with `dec_op` stable until `dec_op_take` is sampled high or a flush occurs.
- R7: When an opcode is taken with `dec_need_mode` high, the next queue byte is given on `dec_mode` with `dec_mode_vld` high for exactly one cycle.
- R8: `xb_vld` is high only while `xb_req` is high, the loader is idle in the execute phase, and the queue is not empty. Each such cycle removes one byte.
- R9: After reset or after `dec_next`, the loader moves the next opcode out of the queue into its holding register without waiting for `dec_op_take`.
- R10: A cycle with `flush` high empties the queue and drops the held opcode. On the next cycle `mem_addr` equals `flush_addr` and `dec_op_vld` is low. A byte fetched before the flush never reaches any output.
- R11: A read and a write in the same cycle keep the occupancy exact. Equal pointers mean empty only when the empty flag is set, and full otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Fetch request to memory |
| mem_addr | output | ADDR_W | Address of the next byte to fetch |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_dvld | input | 1 | Returned byte is valid |
| mem_data | input | 8 | Returned byte |
| flush | input | 1 | Control transfer: discard queue, load new address |
| flush_addr | input | ADDR_W | Target fetch address for a flush |
| dec_op_vld | output | 1 | Held opcode is available |
| dec_op | output | 8 | Held opcode byte |
| dec_op_take | input | 1 | Decoder accepts the held opcode |
| dec_need_mode | input | 1 | With take: an addressing-mode byte follows |
| dec_mode_vld | output | 1 | One-cycle strobe: mode byte on `dec_mode` |
| dec_mode | output | 8 | Addressing-mode byte |
| dec_next | input | 1 | Current instruction ending: prefetch next opcode |
| xb_req | input | 1 | Request one further instruction byte |
| xb_vld | output | 1 | Further byte delivered this cycle |
| xb_data | output | 8 | Further instruction byte |

## Verification
Every memory byte is a fixed function of its address, so each byte that leaves the block can be compared with the value computed from an address counter kept in the bench. This makes loss, duplication, reordering and stale post-flush bytes all show up as miscompares. The stream is tried with grants withheld (the stall case), with steady grants and a consumer that never takes (the capacity and fetch-ahead case), and with a flush from a full queue near the top of the address space (the wrap and discard case). A sweep then crosses return latencies of one to three cycles with steady or irregular grants and with steady or irregular opcode acceptance. The opcode's low bits choose mode and extra-byte counts, so simultaneous reads and writes, wrap of both pointers, and flushes in every loader phase are all reached.

// File: rtl/pfq_loader.sv
module pfq_loader #(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_dvld,
  input  logic [7:0]        mem_data,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  output logic              dec_op_vld,
  output logic [7:0]        dec_op,
  input  logic              dec_op_take,
  input  logic              dec_need_mode,
  output logic              dec_mode_vld,
  output logic [7:0]        dec_mode,
  input  logic              dec_next,
  output logic              xb_vld,
  output logic [7:0]        xb_data,
  input  logic              xb_req
);
  localparam int PW = 2;
  localparam int QD = 1 << PW;

  typedef enum logic [1:0] {L_FILL, L_HOLD, L_MODE, L_WAIT} lst_t;

  logic [7:0]        qmem [QD];
  logic [PW-1:0]     wptr, rptr;
  logic              mt, pend, drop;
  logic [ADDR_W-1:0] fa;
  logic [7:0]        op_q;
  lst_t              st;

  logic full, wr, rd, pop_op, pop_mode, pop_xb, grant;
  logic [7:0] head;

  assign full     = (wptr == rptr) & ~mt;
  assign head     = qmem[rptr];
  assign grant    = mem_req & mem_gnt;
  assign wr       = mem_dvld & pend & ~drop & ~flush;
  assign pop_op   = (st == L_FILL) & ~mt & ~flush;
  assign pop_mode = (st == L_MODE) & ~mt & ~flush;
  assign pop_xb   = (st == L_WAIT) & xb_req & ~mt & ~flush;
  assign rd       = pop_op | pop_mode | pop_xb;

  assign mem_req      = ~pend & ~full;
  assign mem_addr     = fa;
  assign dec_op_vld   = (st == L_HOLD);
  assign dec_op       = op_q;
  assign dec_mode_vld = pop_mode;
  assign dec_mode     = head;
  assign xb_vld       = pop_xb;
  assign xb_data      = head;

  always_ff @(posedge clk) begin
    if (wr) qmem[wptr] <= mem_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      mt   <= 1'b1;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      mt   <= 1'b1;
    end else begin
      if (wr) wptr <= wptr + 1'b1;
      if (rd) rptr <= rptr + 1'b1;
      if (wr)                                   mt <= 1'b0;
      else if (rd && (rptr + 1'b1) == wptr)     mt <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa   <= RESET_ADDR;
      pend <= 1'b0;
      drop <= 1'b0;
    end else begin
      pend <= grant | (pend & ~mem_dvld);
      if (flush)         drop <= grant | (pend & ~mem_dvld);
      else if (mem_dvld) drop <= 1'b0;
      if (flush)      fa <= flush_addr;
      else if (grant) fa <= fa + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= L_FILL;
      op_q <= '0;
    end else if (flush) begin
      st <= L_FILL;
    end else begin
      unique case (st)
        L_FILL: if (pop_op) begin
          st   <= L_HOLD;
          op_q <= head;
        end
        L_HOLD: if (dec_op_take) st <= dec_need_mode ? L_MODE : L_WAIT;
        L_MODE: if (pop_mode) st <= L_WAIT;
        L_WAIT: if (dec_next) st <= L_FILL;
        default: st <= L_FILL;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !full); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !mt); // R5
  AST_EMPTY_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
    mt |-> (wptr == rptr)); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !flush) |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1)); // R2
  AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !mem_dvld) |=> !mem_req); // R2
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> mt && !dec_op_vld && mem_addr == $past(flush_addr)); // R10
  AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op_vld && !dec_op_take && !flush) |=> dec_op_vld && $stable(dec_op)); // R6
  AST_MODE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_mode_vld |=> !dec_mode_vld); // R7
  AST_XB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    xb_vld |-> xb_req && !dec_op_vld && !dec_mode_vld); // R8
endmodule

// File: tb/pfq_loader_tb.sv
module pfq_loader_tb;
  localparam int AW = 20;
  localparam logic [AW-1:0] RST = 20'hFFFF0;
  localparam int P_OP = 0, P_MODE = 1, P_EXEC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_req, mem_gnt = 0, mem_dvld = 0, flush = 0;
  logic [AW-1:0] mem_addr, flush_addr = '0;
  logic [7:0] mem_data = '0, dec_op, dec_mode, xb_data;
  logic dec_op_vld, dec_op_take = 0, dec_need_mode = 0, dec_mode_vld, dec_next = 0;
  logic xb_vld, xb_req = 0;

  always #2 clk = ~clk;

  pfq_loader #(.ADDR_W(AW), .RESET_ADDR(RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_dvld(mem_dvld), .mem_data(mem_data),
    .flush(flush), .flush_addr(flush_addr), .dec_op_vld(dec_op_vld),
    .dec_op(dec_op), .dec_op_take(dec_op_take), .dec_need_mode(dec_need_mode),
    .dec_mode_vld(dec_mode_vld), .dec_mode(dec_mode), .dec_next(dec_next),
    .xb_vld(xb_vld), .xb_data(xb_data), .xb_req(xb_req));

  int n_chk = 0, n_bad = 0, grants = 0, consumed = 0;
  int lat = 0, gmode = 2, tmode = 0, phase = P_OP, xb_left = 0, cnt = 0;
  bit busy = 0, done = 0;
  logic [AW-1:0] maddr, fa_exp, exp_a;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5} ^ 8'h3C;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic step(input bit do_fl, input logic [AW-1:0] tgt);
    int cur;
    bit gok, tok;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_dvld = 0;
    if (busy) begin
      if (cnt == 0) begin
        mem_dvld = 1; mem_data = mbyte(maddr); busy = 0;
      end else cnt--;
    end
    gok = (gmode == 0) ? 1'b1 : (gmode == 1) ? lfsr[0] : 1'b0;
    mem_gnt = mem_req && gok;
    if (mem_gnt) begin
      chk("R2 fetch address", mem_addr, fa_exp);
      fa_exp = fa_exp + 1'b1;
      busy = 1; cnt = lat; maddr = mem_addr; grants++;
    end
    flush = do_fl; flush_addr = tgt;
    dec_op_take = 0; dec_need_mode = 0; dec_next = 0; xb_req = 0;
    cur = phase;
    if (do_fl) begin
      fa_exp = tgt; exp_a = tgt; phase = P_OP; cur = -1;
    end else if (cur == P_OP) begin
      tok = (tmode == 0) ? 1'b1 : (tmode == 1) ? lfsr[1] : 1'b0;
      if (dec_op_vld && tok) begin
        dec_op_take = 1; dec_need_mode = dec_op[0];
        chk("R4 R6 opcode byte", dec_op, mbyte(exp_a));
        exp_a = exp_a + 1'b1; consumed++;
        xb_left = dec_op[2:1];
        phase = dec_op[0] ? P_MODE : P_EXEC;
      end
    end else if (cur == P_EXEC) begin
      if (xb_left > 0) xb_req = 1;
      else begin dec_next = 1; phase = P_OP; end
    end
    #1;
    if (cur == P_MODE) begin
      if (dec_mode_vld) begin
        chk("R7 mode byte", dec_mode, mbyte(exp_a));
        exp_a = exp_a + 1'b1; consumed++; phase = P_EXEC;
      end
    end else if (!do_fl) chk("R7 mode strobe outside mode phase", dec_mode_vld, 0);
    if (xb_req) begin
      if (xb_vld) begin
        chk("R8 R11 extra byte", xb_data, mbyte(exp_a));
        exp_a = exp_a + 1'b1; consumed++; xb_left--;
      end
    end else chk("R8 extra byte without request", xb_vld, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 mem_req", mem_req, 1);
    chk("R1 mem_addr", mem_addr, RST);
    chk("R1 dec_op_vld", dec_op_vld, 0);
    chk("R1 dec_mode_vld", dec_mode_vld, 0);
    chk("R1 xb_vld", xb_vld, 0);
    fa_exp = RST; exp_a = RST;

    gmode = 2; tmode = 0;
    repeat (8) step(0, '0);
    chk("R5 no opcode from empty queue", dec_op_vld, 0);

    gmode = 0; tmode = 2; lat = 1; grants = 0;
    repeat (40) step(0, '0);
    chk("R3 grants until full", grants, 5);
    chk("R3 request dropped when full", mem_req, 0);
    chk("R2 address after five fetches", mem_addr, RST + 20'd5);
    chk("R9 opcode held ahead", dec_op_vld, 1);
    chk("R9 held opcode value", dec_op, mbyte(RST));

    step(1, 20'hFFFFE);
    gmode = 2;
    step(0, '0);
    chk("R10 held opcode dropped", dec_op_vld, 0);
    chk("R10 address reloaded", mem_addr, 20'hFFFFE);
    chk("R10 queue emptied", mem_req, 1);

    for (int l = 0; l < 3; l++)
      for (int g = 0; g < 2; g++)
        for (int t = 0; t < 2; t++) begin
          lat = l; gmode = g; tmode = t;
          for (int i = 0; i < 600; i++) begin
            if (i % 97 == 50) step(1, 20'hFFFF8 + AW'(i) + AW'(l * 7));
            else step(0, '0);
          end
        end
    chk("R4 R11 stream progressed", (consumed > 400) ? 1 : 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule